// File: doc/BRIEF.md
# Interlocked DMA Read-Modify-Write Engine

This engine takes DMA requests from an upstream I/O packet link and carries each one out against a memory bus as one atomic pair of commands. The first command is a locking read and the second is an unlocking write-back. It accepts two kinds of request. The first is an interlocked read, which software uses as a semaphore: bit 0 of the addressed quadword is the lock flag, where 1 means held and 0 means free. The second is a byte-masked write. A masked write that clears bit 0 is also how a holder releases a lock, because the link has no separate release request.

For an interlocked read, the engine always writes the quadword back with bit 0 set. It then returns the data exactly as it was read, tagged so that the upstream adapter can pair the answer with its request. For a masked write, the write-back replaces only the byte lanes that the request enables. The engine checks every arriving packet for byte parity and for the correct sequence number. Link faults and memory failures are both recorded in a sticky error log, which drives an interrupt line until software clears it. Only one request is in flight at any time.

Each memory command arbitrates on a request line chosen from the configured node number. The one exception is the write-back issued by node 8, which uses the dedicated top-priority line so that the bank stays locked for as short a time as possible.

Top module: `ilock_rmw_engine`

## Requirements
- R1: `req_ready` is high only when the engine is idle. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the response has been taken, or for one cycle after a link error is logged.
- R2: After a good request, the engine first issues a locking read (`mem_cmd`=0) at the request address with bits [2:0] forced to zero. That read arbitrates on `mem_arb_req[node_id]`.
- R3: For an interlocked read (`req_kind`=0), the unlocking write-back (`mem_cmd`=1) carries the read data with bit 0 forced to 1, whatever value that bit had when read.
- R4: For a masked write (`req_kind`=1), byte lane i of the write-back (bits 8i+7..8i) is taken from `req_data` when `req_mask[i]`=1, and from the read data otherwise. Bit 0 is not forced, so a masked write can clear the lock flag.
- R5: The write-back arbitrates only on `mem_arb_high` when `node_id`=8. For any other node it arbitrates on `mem_arb_req[node_id]`. Exactly one arbitration line is high while a command is pending, and none is high otherwise.
- R6: A pending command holds its type, address and data stable until the cycle in which `mem_gnt` is high.
- R7: After a successful write-back, the response carries the request's tag and length code, `rsp_err`=0, and the data exactly as read from memory. The response holds until `rsp_ready` is high.
- R8: The link uses even parity per byte, so `req_par[i]` equals the XOR of `req_data` byte i. A parity mismatch logs cause 1 with the request tag, and produces no memory command and no response. When a packet has both a parity fault and a sequence fault, the parity fault takes precedence.
- R9: The expected sequence number is 0 after reset and advances by one for every accepted packet, including a faulty one. A packet whose `req_seq` differs from it logs cause 2 and produces no memory command and no response.
- R10: A memory failure (`mem_rerr` with the read data, or `mem_werr` with the write acknowledge) logs cause 3 and produces a response with `rsp_err`=1 and zero data. A failed read is followed by no write-back.
- R11: `err_irq` is high while the error log holds an entry. The first error logged is kept until `err_clr` is asserted. An error that arrives in the same cycle as `err_clr` is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id | input | NODE_W | Configured node number |
| req_valid | input | 1 | Request packet present |
| req_ready | output | 1 | Engine idle, request can be accepted |
| req_kind | input | 1 | 0 interlocked read, 1 masked write |
| req_addr | input | ADDR_W | Target memory address |
| req_tag | input | TAG_W | Request tag |
| req_len | input | LEN_W | Length code |
| req_data | input | DATA_W | Write data (masked write) |
| req_mask | input | DATA_W/8 | Byte-lane enables (masked write) |
| req_par | input | DATA_W/8 | Even parity per data byte |
| req_seq | input | SEQ_W | Packet sequence number |
| mem_cmd_valid | output | 1 | Memory command pending |
| mem_cmd | output | 1 | 0 locking read, 1 unlocking write |
| mem_addr | output | ADDR_W | Quadword-aligned address |
| mem_wdata | output | DATA_W | Write-back data |
| mem_arb_req | output | 2**NODE_W | Per-node arbitration request lines |
| mem_arb_high | output | 1 | Top-priority arbitration line |
| mem_gnt | input | 1 | Bus grant, command taken |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read data |
| mem_rerr | input | 1 | Read failed |
| mem_wack | input | 1 | Write-back completed |
| mem_werr | input | 1 | Write-back failed |
| rsp_valid | output | 1 | Response packet present |
| rsp_ready | input | 1 | Downstream takes response |
| rsp_tag | output | TAG_W | Tag of the matching request |
| rsp_len | output | LEN_W | Length code echoed |
| rsp_err | output | 1 | Request failed |
| rsp_data | output | DATA_W | Original read data |
| err_irq | output | 1 | Error log holds an entry |
| err_cause | output | 2 | 1 parity, 2 sequence, 3 memory |
| err_tag | output | TAG_W | Tag of the logged request |
| err_clr | input | 1 | Empties the error log |

## Verification
The assertions check the properties that must hold on every cycle:
- one request at a time and a busy engine after each acceptance;
- aligned command addresses;
- exactly one arbitration line while a command waits, and the top-priority line never used for the locking read;
- commands and responses held stable under backpressure;
- a log that stays unchanged until it is cleared;
- zero data on failed responses.

Only the bench scenarios can show the data values:
- bit 0 forced in the write-back while the original value is returned;
- the byte-lane merge;
- the line choice for node 8 compared with other nodes;
- the cause codes and their precedence;
- the sequence counter advancing past a faulty packet;
- the capture of an error that arrives during a clear.

// File: rtl/ilock_rmw_pkg.sv
package ilock_rmw_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_PARITY = 2'd1,
        CAUSE_SEQ    = 2'd2,
        CAUSE_MEM    = 2'd3
    } err_cause_e;

    typedef enum logic {
        CMD_LOCK_RD   = 1'b0,
        CMD_UNLOCK_WR = 1'b1
    } mem_cmd_e;

    typedef enum logic {
        KIND_IREAD  = 1'b0,
        KIND_MWRITE = 1'b1
    } req_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_DROP    = 3'd1,
        ST_RD_ARB  = 3'd2,
        ST_RD_WAIT = 3'd3,
        ST_WR_ARB  = 3'd4,
        ST_WR_WAIT = 3'd5,
        ST_RESP    = 3'd6
    } rmw_state_e;

endpackage

// File: rtl/ilock_rmw_linkcheck.sv
module ilock_rmw_linkcheck #(
    parameter int DATA_W = 64,
    parameter int SEQ_W  = 3,
    localparam int BYTES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [DATA_W-1:0] data,
    input  logic [BYTES-1:0]  par,
    input  logic [SEQ_W-1:0]  seq,
    output logic              par_err,
    output logic              seq_err
);

    logic [SEQ_W-1:0] exp_d, exp_q;
    logic [BYTES-1:0] lane_bad;

    // even parity: byte bits plus parity bit hold an even number of ones
    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        assign lane_bad[g] = (^data[g*8 +: 8]) ^ par[g];
    end

    assign par_err = |lane_bad;
    assign seq_err = (seq != exp_q);

    always_comb begin
        exp_d = exp_q;
        if (accept) begin
            exp_d = exp_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q <= '0;
        end else begin
            exp_q <= exp_d;
        end
    end

endmodule

// File: rtl/ilock_rmw_merge.sv
module ilock_rmw_merge
    import ilock_rmw_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int BYTES = DATA_W / 8
) (
    input  logic              kind,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] new_data,
    input  logic [BYTES-1:0]  mask,
    output logic [DATA_W-1:0] wb_data
);

    logic [DATA_W-1:0] lane;
    logic              is_mwrite;

    assign is_mwrite = (kind == KIND_MWRITE);

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        assign lane[g*8 +: 8] = (is_mwrite && mask[g]) ? new_data[g*8 +: 8]
                                                       : rd_data[g*8 +: 8];
    end

    // interlocked read sets the lock flag in the written copy only
    assign wb_data = {lane[DATA_W-1:1], lane[0] | !is_mwrite};

endmodule

// File: rtl/ilock_rmw_arb_sel.sv
module ilock_rmw_arb_sel #(
    parameter int NODE_W    = 4,
    parameter int HIGH_NODE = 8,
    localparam int N_LINES  = 1 << NODE_W
) (
    input  logic [NODE_W-1:0]  node_id,
    input  logic               active,
    input  logic               writeback,
    output logic [N_LINES-1:0] arb_req,
    output logic               arb_high
);

    logic use_high;

    assign use_high = writeback && (node_id == NODE_W'(HIGH_NODE));
    assign arb_high = active && use_high;

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        assign arb_req[g] = active && !use_high && (node_id == NODE_W'(g));
    end

endmodule

// File: rtl/ilock_rmw_engine.sv
module ilock_rmw_engine
    import ilock_rmw_pkg::*;
#(
    parameter int ADDR_W    = 40,
    parameter int DATA_W    = 64,
    parameter int TAG_W     = 4,
    parameter int LEN_W     = 2,
    parameter int SEQ_W     = 3,
    parameter int NODE_W    = 4,
    parameter int HIGH_NODE = 8,
    localparam int BYTES    = DATA_W / 8,
    localparam int N_LINES  = 1 << NODE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NODE_W-1:0]  node_id,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_kind,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [TAG_W-1:0]   req_tag,
    input  logic [LEN_W-1:0]   req_len,
    input  logic [DATA_W-1:0]  req_data,
    input  logic [BYTES-1:0]   req_mask,
    input  logic [BYTES-1:0]   req_par,
    input  logic [SEQ_W-1:0]   req_seq,
    output logic               mem_cmd_valid,
    output logic               mem_cmd,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic [N_LINES-1:0] mem_arb_req,
    output logic               mem_arb_high,
    input  logic               mem_gnt,
    input  logic               mem_rvalid,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic               mem_rerr,
    input  logic               mem_wack,
    input  logic               mem_werr,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [TAG_W-1:0]   rsp_tag,
    output logic [LEN_W-1:0]   rsp_len,
    output logic               rsp_err,
    output logic [DATA_W-1:0]  rsp_data,
    output logic               err_irq,
    output logic [1:0]         err_cause,
    output logic [TAG_W-1:0]   err_tag,
    input  logic               err_clr
);

    localparam logic [ADDR_W-1:0] QW_MASK = ~ADDR_W'(7);

    typedef struct packed {
        rmw_state_e         st;
        logic               kind;
        logic [ADDR_W-1:0]  addr;
        logic [TAG_W-1:0]   tag;
        logic [LEN_W-1:0]   len;
        logic [DATA_W-1:0]  ndata;
        logic [BYTES-1:0]   mask;
        logic [DATA_W-1:0]  rdata;
        logic               fail;
        logic               log_v;
        logic [1:0]         log_cause;
        logic [TAG_W-1:0]   log_tag;
    } eng_s;

    eng_s q, d;

    logic             accept;
    logic             par_err;
    logic             seq_err;
    logic             new_err;
    logic [1:0]       new_cause;
    logic [TAG_W-1:0] new_tag;

    assign accept = req_valid && (q.st == ST_IDLE);

    ilock_rmw_linkcheck #(
        .DATA_W (DATA_W),
        .SEQ_W  (SEQ_W)
    ) u_link (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .data    (req_data),
        .par     (req_par),
        .seq     (req_seq),
        .par_err (par_err),
        .seq_err (seq_err)
    );

    ilock_rmw_merge #(
        .DATA_W (DATA_W)
    ) u_merge (
        .kind     (q.kind),
        .rd_data  (q.rdata),
        .new_data (q.ndata),
        .mask     (q.mask),
        .wb_data  (mem_wdata)
    );

    ilock_rmw_arb_sel #(
        .NODE_W    (NODE_W),
        .HIGH_NODE (HIGH_NODE)
    ) u_arb (
        .node_id   (node_id),
        .active    (mem_cmd_valid),
        .writeback (q.st == ST_WR_ARB),
        .arb_req   (mem_arb_req),
        .arb_high  (mem_arb_high)
    );

    always_comb begin
        d         = q;
        new_err   = 1'b0;
        new_cause = CAUSE_NONE;
        new_tag   = q.tag;

        unique case (q.st)
            ST_IDLE: begin
                if (accept) begin
                    d.kind  = req_kind;
                    d.addr  = req_addr;
                    d.tag   = req_tag;
                    d.len   = req_len;
                    d.ndata = req_data;
                    d.mask  = req_mask;
                    d.rdata = '0;
                    d.fail  = 1'b0;
                    if (par_err || seq_err) begin
                        new_err   = 1'b1;
                        new_cause = par_err ? CAUSE_PARITY : CAUSE_SEQ;
                        new_tag   = req_tag;
                        d.st      = ST_DROP;
                    end else begin
                        d.st = ST_RD_ARB;
                    end
                end
            end
            ST_DROP: begin
                d.st = ST_IDLE;
            end
            ST_RD_ARB: begin
                if (mem_gnt) begin
                    d.st = ST_RD_WAIT;
                end
            end
            ST_RD_WAIT: begin
                if (mem_rvalid) begin
                    d.rdata = mem_rdata;
                    if (mem_rerr) begin
                        d.fail    = 1'b1;
                        new_err   = 1'b1;
                        new_cause = CAUSE_MEM;
                        d.st      = ST_RESP;
                    end else begin
                        d.st = ST_WR_ARB;
                    end
                end
            end
            ST_WR_ARB: begin
                if (mem_gnt) begin
                    d.st = ST_WR_WAIT;
                end
            end
            ST_WR_WAIT: begin
                if (mem_wack) begin
                    if (mem_werr) begin
                        d.fail    = 1'b1;
                        new_err   = 1'b1;
                        new_cause = CAUSE_MEM;
                    end
                    d.st = ST_RESP;
                end
            end
            ST_RESP: begin
                if (rsp_ready) begin
                    d.st = ST_IDLE;
                end
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase

        if (err_clr) begin
            d.log_v = 1'b0;
        end
        if (new_err && (!q.log_v || err_clr)) begin
            d.log_v     = 1'b1;
            d.log_cause = new_cause;
            d.log_tag   = new_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready     = (q.st == ST_IDLE);
    assign mem_cmd_valid = (q.st == ST_RD_ARB) || (q.st == ST_WR_ARB);
    assign mem_cmd       = (q.st == ST_WR_ARB) ? CMD_UNLOCK_WR : CMD_LOCK_RD;
    assign mem_addr      = q.addr & QW_MASK;

    assign rsp_valid = (q.st == ST_RESP);
    assign rsp_tag   = q.tag;
    assign rsp_len   = q.len;
    assign rsp_err   = q.fail;
    assign rsp_data  = q.fail ? '0 : q.rdata;

    assign err_irq   = q.log_v;
    assign err_cause = q.log_cause;
    assign err_tag   = q.log_tag;

endmodule

// File: rtl/ilock_rmw_engine_chk.sv
module ilock_rmw_engine_chk #(
    parameter int ADDR_W  = 40,
    parameter int DATA_W  = 64,
    parameter int TAG_W   = 4,
    parameter int N_LINES = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               mem_cmd_valid,
    input logic               mem_cmd,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic [DATA_W-1:0]  mem_wdata,
    input logic [N_LINES-1:0] mem_arb_req,
    input logic               mem_arb_high,
    input logic               mem_gnt,
    input logic               rsp_valid,
    input logic               rsp_ready,
    input logic [TAG_W-1:0]   rsp_tag,
    input logic [DATA_W-1:0]  rsp_data,
    input logic               rsp_err,
    input logic               err_irq,
    input logic [1:0]         err_cause,
    input logic [TAG_W-1:0]   err_tag,
    input logic               err_clr
);

    // R1
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R1
    busy_during_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R2
    aligned_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cmd_valid |-> (mem_addr[2:0] == 3'b000));

    // R5
    one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cmd_valid |-> ($countones({mem_arb_req, mem_arb_high}) == 1));

    // R5
    quiet_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cmd_valid |-> ({mem_arb_req, mem_arb_high} == '0));

    // R5
    read_not_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd_valid && !mem_cmd) |-> !mem_arb_high);

    // R6
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd_valid && !mem_gnt) |=>
        (mem_cmd_valid && $stable(mem_cmd) && $stable(mem_addr) && $stable(mem_wdata)));

    // R7
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=>
        (rsp_valid && $stable(rsp_tag) && $stable(rsp_data) && $stable(rsp_err)));

    // R10
    fail_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_data == '0));

    // R11
    log_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_irq && !err_clr) |=> (err_irq && $stable(err_cause) && $stable(err_tag)));

endmodule

bind ilock_rmw_engine ilock_rmw_engine_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .TAG_W   (TAG_W),
    .N_LINES (N_LINES)
) u_chk (.*);

// File: tb/ilock_rmw_engine_bench.sv
module ilock_rmw_engine_bench;

    localparam int ADDR_W  = 40;
    localparam int DATA_W  = 64;
    localparam int TAG_W   = 4;
    localparam int LEN_W   = 2;
    localparam int SEQ_W   = 3;
    localparam int NODE_W  = 4;
    localparam int BYTES   = DATA_W / 8;
    localparam int N_LINES = 1 << NODE_W;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NODE_W-1:0]  node_id = '0;
    logic               req_valid = 1'b0;
    logic               req_ready;
    logic               req_kind = 1'b0;
    logic [ADDR_W-1:0]  req_addr = '0;
    logic [TAG_W-1:0]   req_tag = '0;
    logic [LEN_W-1:0]   req_len = '0;
    logic [DATA_W-1:0]  req_data = '0;
    logic [BYTES-1:0]   req_mask = '0;
    logic [BYTES-1:0]   req_par = '0;
    logic [SEQ_W-1:0]   req_seq = '0;
    logic               mem_cmd_valid;
    logic               mem_cmd;
    logic [ADDR_W-1:0]  mem_addr;
    logic [DATA_W-1:0]  mem_wdata;
    logic [N_LINES-1:0] mem_arb_req;
    logic               mem_arb_high;
    logic               mem_gnt = 1'b0;
    logic               mem_rvalid = 1'b0;
    logic [DATA_W-1:0]  mem_rdata = '0;
    logic               mem_rerr = 1'b0;
    logic               mem_wack = 1'b0;
    logic               mem_werr = 1'b0;
    logic               rsp_valid;
    logic               rsp_ready = 1'b0;
    logic [TAG_W-1:0]   rsp_tag;
    logic [LEN_W-1:0]   rsp_len;
    logic               rsp_err;
    logic [DATA_W-1:0]  rsp_data;
    logic               err_irq;
    logic [1:0]         err_cause;
    logic [TAG_W-1:0]   err_tag;
    logic               err_clr = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    logic [SEQ_W-1:0] exp_seq = '0;

    logic [ADDR_W-1:0]  cap_addr;
    logic [N_LINES-1:0] cap_rd_lines, cap_wr_lines;
    logic               cap_rd_high, cap_wr_high;
    logic [DATA_W-1:0]  cap_wdata;
    logic [TAG_W-1:0]   cap_tag;
    logic [LEN_W-1:0]   cap_len;
    logic               cap_err;
    logic [DATA_W-1:0]  cap_data;

    always #2 clk = ~clk;

    ilock_rmw_engine u_ilock_rmw_engine (.*);

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    function automatic logic [BYTES-1:0] even_par(input logic [DATA_W-1:0] v);
        logic [BYTES-1:0] p;
        for (int i = 0; i < BYTES; i++) p[i] = ^v[i*8 +: 8];
        return p;
    endfunction

    function automatic logic [DATA_W-1:0] lane_mix(input logic [DATA_W-1:0] rd,
            input logic [DATA_W-1:0] nw, input logic [BYTES-1:0] m);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < BYTES; i++) r[i*8 +: 8] = m[i] ? nw[i*8 +: 8] : rd[i*8 +: 8];
        return r;
    endfunction

    task automatic send(input logic kind, input logic [ADDR_W-1:0] addr,
            input logic [TAG_W-1:0] tag, input logic [LEN_W-1:0] len,
            input logic [DATA_W-1:0] data, input logic [BYTES-1:0] mask,
            input logic bad_par, input logic bad_seq, input logic clr);
        @(negedge clk);
        chk("R1 ready while idle", req_ready, 1);
        req_kind  = kind;
        req_addr  = addr;
        req_tag   = tag;
        req_len   = len;
        req_data  = data;
        req_mask  = mask;
        req_par   = even_par(data) ^ (bad_par ? 8'h04 : 8'h00);
        req_seq   = exp_seq + (bad_seq ? 3'd1 : 3'd0);
        req_valid = 1'b1;
        err_clr   = clr;
        @(negedge clk);
        req_valid = 1'b0;
        err_clr   = 1'b0;
        exp_seq   = exp_seq + 1'b1;
        chk("R1 busy after accept", req_ready, 0);
    endtask

    task automatic serve(input logic [DATA_W-1:0] rd, input logic rerr,
            input logic werr, input int gdelay);
        int i = 0;
        while (!(mem_cmd_valid && mem_cmd == 1'b0) && i < 20) begin
            @(negedge clk);
            i++;
        end
        chk("R2 locking read issued", mem_cmd_valid && mem_cmd == 1'b0, 1);
        cap_addr     = mem_addr;
        cap_rd_lines = mem_arb_req;
        cap_rd_high  = mem_arb_high;
        for (int k = 0; k < gdelay; k++) begin
            @(negedge clk);
            chk("R6 read held without grant", {mem_cmd_valid, mem_cmd, mem_addr},
                {1'b1, 1'b0, cap_addr});
        end
        mem_gnt = 1'b1;
        @(negedge clk);
        mem_gnt    = 1'b0;
        mem_rvalid = 1'b1;
        mem_rdata  = rd;
        mem_rerr   = rerr;
        @(negedge clk);
        mem_rvalid = 1'b0;
        mem_rerr   = 1'b0;
        if (rerr) begin
            chk("R10 no write-back after failed read", mem_cmd_valid, 0);
        end else begin
            chk("R3 unlocking write issued", mem_cmd_valid && mem_cmd == 1'b1, 1);
            cap_wdata    = mem_wdata;
            cap_wr_lines = mem_arb_req;
            cap_wr_high  = mem_arb_high;
            for (int k = 0; k < gdelay; k++) begin
                @(negedge clk);
                chk("R6 write held without grant", {mem_cmd_valid, mem_wdata},
                    {1'b1, cap_wdata});
            end
            mem_gnt = 1'b1;
            @(negedge clk);
            mem_gnt  = 1'b0;
            mem_wack = 1'b1;
            mem_werr = werr;
            @(negedge clk);
            mem_wack = 1'b0;
            mem_werr = 1'b0;
        end
    endtask

    task automatic take_rsp();
        int i = 0;
        while (!rsp_valid && i < 10) begin
            @(negedge clk);
            i++;
        end
        chk("R7 response present", rsp_valid, 1);
        cap_tag  = rsp_tag;
        cap_len  = rsp_len;
        cap_err  = rsp_err;
        cap_data = rsp_data;
        @(negedge clk);
        chk("R7 response held without ready", {rsp_valid, rsp_tag, rsp_data},
            {1'b1, cap_tag, cap_data});
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk("R1 idle after response", {rsp_valid, req_ready}, 2'b01);
    endtask

    task automatic quiet_after_drop(input string what);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(what, {mem_cmd_valid, rsp_valid}, 2'b00);
        end
    endtask

    task automatic clear_log();
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        chk("R11 clear empties log", err_irq, 0);
    endtask

    task automatic t_reset();
        chk("R1 reset ready", req_ready, 1);
        chk("R5 reset lines idle", {mem_cmd_valid, mem_arb_req, mem_arb_high}, 0);
        chk("R11 reset log empty", {rsp_valid, err_irq}, 0);
    endtask

    task automatic t_iread_free();
        logic [DATA_W-1:0] rd = 64'hDEAD_BEEF_0000_1110;
        node_id = 4'd3;
        send(1'b0, 40'h12_3456_7808, 4'd5, 2'd2, '0, '0, 0, 0, 0);
        serve(rd, 0, 0, 0);
        chk("R2 read address", cap_addr, 40'h12_3456_7808);
        chk("R2 read line node 3", {cap_rd_lines, cap_rd_high}, {16'h0008, 1'b0});
        chk("R3 lock bit forced", cap_wdata, rd | 64'h1);
        chk("R5 write-back line node 3", {cap_wr_lines, cap_wr_high}, {16'h0008, 1'b0});
        take_rsp();
        chk("R7 tag/len/err", {cap_tag, cap_len, cap_err}, {4'd5, 2'd2, 1'b0});
        chk("R7 original data returned", cap_data, rd);
    endtask

    task automatic t_iread_held_node8();
        logic [DATA_W-1:0] rd = 64'h0123_4567_89AB_CDEF;
        node_id = 4'd8;
        send(1'b0, 40'h00_0000_1000, 4'd11, 2'd1, '0, '0, 0, 0, 0);
        serve(rd, 0, 0, 3);
        chk("R2 read line node 8", {cap_rd_lines, cap_rd_high}, {16'h0100, 1'b0});
        chk("R5 node 8 write-back on high line", {cap_wr_lines, cap_wr_high}, {16'h0000, 1'b1});
        chk("R3 already locked stays set", cap_wdata, rd);
        take_rsp();
        chk("R7 node 8 response", {cap_tag, cap_len, cap_err}, {4'd11, 2'd1, 1'b0});
        chk("R7 lock bit returned as read", cap_data, rd);
    endtask

    task automatic t_mwrite_release();
        logic [DATA_W-1:0] rd = 64'hFFEE_DDCC_BBAA_9981;
        logic [DATA_W-1:0] nw = 64'h1122_3344_5566_7700;
        node_id = 4'd3;
        send(1'b1, 40'h00_00AB_CD10, 4'd2, 2'd0, nw, 8'hA5, 0, 0, 0);
        serve(rd, 0, 0, 1);
        chk("R4 byte merge mask A5", cap_wdata, lane_mix(rd, nw, 8'hA5));
        chk("R4 lock released bit0", cap_wdata[0], 0);
        take_rsp();
        chk("R7 masked write response", {cap_tag, cap_err, cap_data}, {4'd2, 1'b0, rd});
    endtask

    task automatic t_mwrite_nomask();
        logic [DATA_W-1:0] rd = 64'hA5A5_5A5A_0F0F_F0F0;
        node_id = 4'd15;
        send(1'b1, 40'h77_0000_002D, 4'd3, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00, 0, 0, 0);
        serve(rd, 0, 0, 0);
        chk("R2 low address bits cleared", cap_addr, 40'h77_0000_0028);
        chk("R4 empty mask keeps memory", cap_wdata, rd);
        chk("R5 node 15 lines", {cap_wr_lines, cap_wr_high}, {16'h8000, 1'b0});
        take_rsp();
    endtask

    task automatic t_parity();
        send(1'b0, 40'h10, 4'd9, 2'd0, 64'h0000_0000_00FF_0001, '0, 1, 0, 0);
        chk("R8 parity logged", {err_irq, err_cause, err_tag}, {1'b1, 2'd1, 4'd9});
        quiet_after_drop("R8 no command or response after parity fault");
        clear_log();
    endtask

    task automatic t_sequence();
        logic [DATA_W-1:0] rd = 64'h0000_0000_0000_0042;
        node_id = 4'd3;
        send(1'b0, 40'h20, 4'd6, 2'd0, '0, '0, 0, 1, 0);
        chk("R9 sequence fault logged", {err_irq, err_cause, err_tag}, {1'b1, 2'd2, 4'd6});
        quiet_after_drop("R9 no command or response after sequence fault");
        send(1'b0, 40'h28, 4'd7, 2'd0, '0, '0, 0, 0, 0);
        serve(rd, 0, 0, 0);
        take_rsp();
        chk("R9 counter advanced past faulty packet", {cap_tag, cap_err}, {4'd7, 1'b0});
        chk("R11 first error kept", {err_irq, err_cause, err_tag}, {1'b1, 2'd2, 4'd6});
        clear_log();
        send(1'b0, 40'h30, 4'd10, 2'd0, 64'h1, '0, 1, 1, 0);
        chk("R8 parity wins over sequence", {err_cause, err_tag}, {2'd1, 4'd10});
        quiet_after_drop("R8 dual fault dropped");
        clear_log();
    endtask

    task automatic t_mem_fail();
        node_id = 4'd1;
        send(1'b0, 40'h40, 4'd13, 2'd1, '0, '0, 0, 0, 0);
        serve(64'hFFFF_0000_FFFF_0000, 1, 0, 0);
        take_rsp();
        chk("R10 read fail response", {cap_tag, cap_err, cap_data}, {4'd13, 1'b1, 64'h0});
        chk("R10 read fail logged", {err_irq, err_cause, err_tag}, {1'b1, 2'd3, 4'd13});
        clear_log();
        send(1'b1, 40'h48, 4'd14, 2'd0, 64'h5, 8'h01, 0, 0, 0);
        serve(64'h1234, 0, 1, 0);
        take_rsp();
        chk("R10 write fail response", {cap_tag, cap_err, cap_data}, {4'd14, 1'b1, 64'h0});
        chk("R10 write fail logged", {err_cause, err_tag}, {2'd3, 4'd14});
        send(1'b0, 40'h50, 4'd12, 2'd0, 64'h3, '0, 1, 0, 1);
        chk("R11 error during clear captured", {err_irq, err_cause, err_tag}, {1'b1, 2'd1, 4'd12});
        quiet_after_drop("R8 dropped during clear");
        clear_log();
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_iread_free();
        t_iread_held_node8();
        t_mwrite_release();
        t_mwrite_nomask();
        t_parity();
        t_sequence();
        t_mem_fail();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule